// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status flags of an asynchronous serial port. It sits between the receive and transmit shift engines and a CPU register bus. The engines report events as single-cycle pulses: a frame was received, with its stop bits, its parity result and its multiprocessor bit, and the last bit of a character was shifted out. The block turns these pulses into sticky flags and exposes them as one 8-bit status word. The receive-data-full and transmit-data-empty flags are kept elsewhere and only pass through the word.

The three receive error flags are cleared safely. Software must first read a flag as 1, which arms it. A later write of 0 to that bit then clears the flag. A write of 0 to a flag that was never read as 1 does nothing. The transmit-end flag follows the same read-then-write rule, but the read that arms it is a read of the data-empty bit. An agent that refills the transmit data register can also clear it. The block also captures the multiprocessor bit of each received frame and holds the software-written multiprocessor bit that is appended to each transmitted frame.

All pins are plain control and status signals. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_flag_bank`

## Requirements
- R1: Overrun flag (bit 5) becomes 1 one cycle after `rx_done` is high while `rdata_full` is 1. A reception while `rdata_full` is 0 leaves it at 0.
- R2: Framing flag (bit 4) becomes 1 after `rx_done` when `rx_stop_bits[0]` (first stop bit) is 0. `rx_stop_bits[1]` (second stop bit) has no effect on the flag.
- R3: Parity flag (bit 3) becomes 1 one cycle after `rx_done` with `rx_par_err` high.
- R4: An error flag clears only when a bus write carries 0 in its bit after a bus read returned that bit as 1. A write of 0 with no preceding qualifying read leaves the flag at 1. A completed clear disarms the flag.
- R5: A bus write carrying 1 in an error flag's bit never changes that flag.
- R6: If a set event and a qualifying clear write happen in the same cycle, the flag stays 1. The clear write still disarms the flag.
- R7: Transmit-end flag (bit 2) is 1 after reset. It is held at 1 while `tx_en` is 0. It becomes 1 one cycle after `tx_last_bit` while `tdata_empty` is 1.
- R8: Transmit-end flag clears after a bus write with bit 6 = 0 that follows a read returning bit 6 as 1. It also clears one cycle after a `dma_tdr_wr` pulse.
- R9: Transmit-end flag is read-only: writing 0 to bit 2 has no effect.
- R10: Received multiprocessor bit (bit 1) takes `rx_mp_bit` on `rx_done` while `rx_en` is 1. It keeps its value while `rx_en` is 0.
- R11: Multiprocessor transmit bit (bit 0, driven on `mp_tx_bit`) resets to 0 and takes `bus_wdata[0]` on every bus write.
- R12: `rd_data` is {`rdata_full`, `tdata_empty`, overrun, framing, parity, transmit-end, received MP bit, MP transmit bit}, from bit 7 down to bit 0. Bits 7 and 6 follow their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| rx_done | input | 1 | Pulse: a frame has been received |
| rx_stop_bits | input | 2 | Sampled stop bits with rx_done; [0] first, [1] second |
| rx_par_err | input | 1 | Parity mismatch with rx_done |
| rx_mp_bit | input | 1 | Received multiprocessor bit with rx_done |
| tx_last_bit | input | 1 | Pulse: last bit of a character sent |
| rdata_full | input | 1 | Receive-data-full flag from outside |
| tdata_empty | input | 1 | Transmit-data-empty flag from outside |
| dma_tdr_wr | input | 1 | Pulse: transmit data register written by transfer agent |
| bus_rd | input | 1 | Status register read strobe |
| bus_wr | input | 1 | Status register write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Status word |
| mp_tx_bit | output | 1 | Multiprocessor bit for the transmitter |

## Verification
Every flag update is registered, so an event or write strobe present at one rising edge shows up in `rd_data` just after that edge. Bits 7 and 6 are combinational and are due in the same cycle. Arming is also registered: a read at one edge can enable a clear no earlier than the write at the next edge. The bench drives each strobe for one cycle starting at a falling edge and samples at the following falling edge, which is exactly one edge later. Reads are sampled a nanosecond after the strobe is driven.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_ERR = 3;
  // bit positions in the status word
  localparam int unsigned POS_RDF = 7;
  localparam int unsigned POS_TDE = 6;
  localparam int unsigned POS_OVR = 5;
  localparam int unsigned POS_FRM = 4;
  localparam int unsigned POS_PAR = 3;
  localparam int unsigned POS_TXE = 2;
  localparam int unsigned POS_MPR = 1;
  localparam int unsigned POS_MPT = 0;
  // error flags occupy POS_OVR downwards, index 0 = overrun
  localparam int unsigned ERR_TOP = POS_OVR;
endpackage

// File: rtl/flag_cell.sv
module flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic arm_src_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  input  logic force_clr_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;
  logic clr_wr;

  assign clr_wr = wr_i && armed_q && !wr_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      if (clr_wr)
        armed_q <= 1'b0;
      else if (rd_i && arm_src_i)
        armed_q <= 1'b1;
      if (set_i)
        flag_q <= 1'b1;
      else if (clr_wr || force_clr_i)
        flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/err_detect.sv
module err_detect
  import uart_flag_pkg::*;
(
  input  logic               rx_done_i,
  input  logic [1:0]         stop_bits_i,
  input  logic               par_err_i,
  input  logic               rdata_full_i,
  output logic [NUM_ERR-1:0] set_o
);
  logic unused_second_stop;
  assign unused_second_stop = stop_bits_i[1];

  // index 0 overrun, 1 framing, 2 parity
  assign set_o[0] = rx_done_i && rdata_full_i;
  assign set_o[1] = rx_done_i && !stop_bits_i[0];
  assign set_o[2] = rx_done_i && par_err_i;
endmodule

// File: rtl/mp_bit_unit.sv
module mp_bit_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en_i,
  input  logic rx_done_i,
  input  logic rx_mp_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic mp_rx_o,
  output logic mp_tx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp_rx_o <= 1'b0;
      mp_tx_o <= 1'b0;
    end else begin
      if (rx_en_i && rx_done_i) mp_rx_o <= rx_mp_i;
      if (wr_i) mp_tx_o <= wr_bit_i;
    end
  end
endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank
  import uart_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             rx_done,
  input  logic [1:0]       rx_stop_bits,
  input  logic             rx_par_err,
  input  logic             rx_mp_bit,
  input  logic             tx_last_bit,
  input  logic             rdata_full,
  input  logic             tdata_empty,
  input  logic             dma_tdr_wr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] rd_data,
  output logic             mp_tx_bit
);
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_flag;
  logic               txe_flag;
  logic               txe_set;
  logic               mp_rx;
  logic [2:0]         unused_wbits;

  assign unused_wbits = {bus_wdata[POS_RDF], bus_wdata[POS_TXE], bus_wdata[POS_MPR]};

  err_detect u_det (
    .rx_done_i    (rx_done),
    .stop_bits_i  (rx_stop_bits),
    .par_err_i    (rx_par_err),
    .rdata_full_i (rdata_full),
    .set_o        (err_set)
  );

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    flag_cell #(.RST_VAL(1'b0)) u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (err_set[g]),
      .arm_src_i   (err_flag[g]),
      .rd_i        (bus_rd),
      .wr_i        (bus_wr),
      .wr_bit_i    (bus_wdata[ERR_TOP-g]),
      .force_clr_i (1'b0),
      .flag_o      (err_flag[g])
    );
  end

  assign txe_set = !tx_en || (tx_last_bit && tdata_empty);

  flag_cell #(.RST_VAL(1'b1)) u_txe (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (txe_set),
    .arm_src_i   (tdata_empty),
    .rd_i        (bus_rd),
    .wr_i        (bus_wr),
    .wr_bit_i    (bus_wdata[POS_TDE]),
    .force_clr_i (dma_tdr_wr),
    .flag_o      (txe_flag)
  );

  mp_bit_unit u_mp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en_i   (rx_en),
    .rx_done_i (rx_done),
    .rx_mp_i   (rx_mp_bit),
    .wr_i      (bus_wr),
    .wr_bit_i  (bus_wdata[POS_MPT]),
    .mp_rx_o   (mp_rx),
    .mp_tx_o   (mp_tx_bit)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[POS_RDF] = rdata_full;
    rd_data[POS_TDE] = tdata_empty;
    for (int i = 0; i < NUM_ERR; i++) rd_data[ERR_TOP-i] = err_flag[i];
    rd_data[POS_TXE] = txe_flag;
    rd_data[POS_MPR] = mp_rx;
    rd_data[POS_MPT] = mp_tx_bit;
  end
endmodule

// File: rtl/uart_flag_bank_chk.sv
module uart_flag_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       tx_en,
  input logic       rx_done,
  input logic [1:0] rx_stop_bits,
  input logic       rx_par_err,
  input logic       rdata_full,
  input logic       dma_tdr_wr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] rd_data,
  input logic       mp_tx_bit
);
  // R1
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rdata_full |=> rd_data[5]);
  // R2
  frm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_stop_bits[0] |=> rd_data[4]);
  // R3
  par_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_par_err |=> rd_data[3]);
  // R4
  err_fall_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[5]) || $fell(rd_data[4]) || $fell(rd_data[3]) |-> $past(bus_wr));
  // R5
  ovr_wr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[5] |=> !$fell(rd_data[5]));
  // R7
  txe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> rd_data[2]);
  // R8
  txe_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[2]) |-> $past(bus_wr) || $past(dma_tdr_wr));
  // R10
  mpr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(rd_data[1]));
  // R11
  mpt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> mp_tx_bit == $past(bus_wdata[0]));
endmodule

bind uart_flag_bank uart_flag_bank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .tx_en        (tx_en),
  .rx_done      (rx_done),
  .rx_stop_bits (rx_stop_bits),
  .rx_par_err   (rx_par_err),
  .rdata_full   (rdata_full),
  .dma_tdr_wr   (dma_tdr_wr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .rd_data      (rd_data),
  .mp_tx_bit    (mp_tx_bit)
);

// File: tb/uart_flag_bank_tb.sv
module uart_flag_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, tx_en = 1'b0, rx_done = 1'b0;
  logic [1:0] rx_stop_bits = 2'b11;
  logic       rx_par_err = 1'b0, rx_mp_bit = 1'b0, tx_last_bit = 1'b0;
  logic       rdata_full = 1'b0, tdata_empty = 1'b0, dma_tdr_wr = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       mp_tx_bit;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_flag_bank u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .rx_done(rx_done),
    .rx_stop_bits(rx_stop_bits), .rx_par_err(rx_par_err), .rx_mp_bit(rx_mp_bit),
    .tx_last_bit(tx_last_bit), .rdata_full(rdata_full), .tdata_empty(tdata_empty),
    .dma_tdr_wr(dma_tdr_wr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .mp_tx_bit(mp_tx_bit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one receive pulse; flags visible at the next falling edge
  task automatic rx_frame(input logic [1:0] stop, input logic perr, input logic mp);
    @(negedge clk);
    rx_done = 1'b1; rx_stop_bits = stop; rx_par_err = perr; rx_mp_bit = mp;
    @(negedge clk);
    rx_done = 1'b0; rx_stop_bits = 2'b11; rx_par_err = 1'b0; rx_mp_bit = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R7 reset word", rd_data, 8'h04);
    chk("R11 reset mp_tx_bit", {7'd0, mp_tx_bit}, 8'h00);
  endtask

  task automatic t_overrun;
    rx_frame(2'b11, 1'b0, 1'b0);
    chk("R1 no overrun when not full", {7'd0, rd_data[5]}, 8'h00);
    rdata_full = 1'b1;
    rx_frame(2'b11, 1'b0, 1'b0);
    chk("R1 overrun set", {7'd0, rd_data[5]}, 8'h01);
    rdata_full = 1'b0;
  endtask

  task automatic t_framing;
    rx_frame(2'b01, 1'b0, 1'b0);
    chk("R2 second stop bit ignored", {7'd0, rd_data[4]}, 8'h00);
    rx_frame(2'b10, 1'b0, 1'b0);
    chk("R2 first stop bit zero", {7'd0, rd_data[4]}, 8'h01);
  endtask

  task automatic t_parity;
    rx_frame(2'b11, 1'b1, 1'b0);
    chk("R3 parity set", {7'd0, rd_data[3]}, 8'h01);
  endtask

  task automatic t_clear_rule;
    logic [7:0] v;
    bus_write(8'h18);
    chk("R4 write 0 without read", {7'd0, rd_data[5]}, 8'h01);
    bus_read(v);
    chk("R12 read shows errors", {5'd0, v[5:3]}, 8'h07);
    bus_write(8'h38);
    chk("R5 write 1 no effect", {7'd0, rd_data[5]}, 8'h01);
    bus_write(8'h18);
    chk("R4 read then write 0 clears", {5'd0, rd_data[5:3]}, 8'h03);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    rdata_full = 1'b1;
    rx_frame(2'b11, 1'b0, 1'b0);
    bus_read(v);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h18; rx_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rx_done = 1'b0;
    chk("R6 set wins over clear", {7'd0, rd_data[5]}, 8'h01);
    bus_write(8'h18);
    chk("R6 clear write disarmed", {7'd0, rd_data[5]}, 8'h01);
    rdata_full = 1'b0;
  endtask

  task automatic t_tx_end;
    logic [7:0] v;
    @(negedge clk); tx_en = 1'b1; tdata_empty = 1'b1;
    bus_write(8'h38);
    chk("R8 no clear without read", {7'd0, rd_data[2]}, 8'h01);
    bus_write(8'h3B);
    chk("R9 write 0 to bit2 ignored", {7'd0, rd_data[2]}, 8'h01);
    bus_read(v);
    chk("R12 read data-empty bit", {7'd0, v[6]}, 8'h01);
    bus_write(8'h38);
    chk("R8 read then write 0 clears", {7'd0, rd_data[2]}, 8'h00);
    @(negedge clk); tx_last_bit = 1'b1;
    @(negedge clk); tx_last_bit = 1'b0;
    chk("R7 last bit with empty sets", {7'd0, rd_data[2]}, 8'h01);
    @(negedge clk); dma_tdr_wr = 1'b1;
    @(negedge clk); dma_tdr_wr = 1'b0;
    chk("R8 agent write clears", {7'd0, rd_data[2]}, 8'h00);
    tdata_empty = 1'b0;
    @(negedge clk); tx_last_bit = 1'b1;
    @(negedge clk); tx_last_bit = 1'b0;
    chk("R7 last bit not empty", {7'd0, rd_data[2]}, 8'h00);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    chk("R7 disabled sets", {7'd0, rd_data[2]}, 8'h01);
  endtask

  task automatic t_mp;
    @(negedge clk); rx_en = 1'b1;
    rx_frame(2'b11, 1'b0, 1'b1);
    chk("R10 capture mp bit", {7'd0, rd_data[1]}, 8'h01);
    @(negedge clk); rx_en = 1'b0;
    rx_frame(2'b11, 1'b0, 1'b0);
    chk("R10 hold while disabled", {7'd0, rd_data[1]}, 8'h01);
    bus_write(8'h39);
    chk("R11 mp tx bit written", {6'd0, rd_data[0], mp_tx_bit}, 8'h03);
    bus_write(8'h38);
    chk("R11 mp tx bit cleared", {7'd0, mp_tx_bit}, 8'h00);
  endtask

  task automatic t_passthru;
    @(negedge clk); rdata_full = 1'b1; tdata_empty = 1'b0;
    #1 chk("R12 pass-through 10", {6'd0, rd_data[7:6]}, 8'h02);
    rdata_full = 1'b0; tdata_empty = 1'b1;
    #1 chk("R12 pass-through 01", {6'd0, rd_data[7:6]}, 8'h01);
    tdata_empty = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_overrun();
    t_framing();
    t_parity();
    t_clear_rule();
    t_set_wins();
    t_tx_end();
    t_mp();
    t_passthru();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule